// File: doc/BRIEF.md
# Data-Dependent Early-Exit Vector Loop Controller

This controller walks a vector operation one element at a time, in ascending index order, and decides after each element whether the loop may go on. An external datapath computes each element and returns a four-bit condition field and a floating-point exception flag through a simple valid strobe. The controller tests that field against a programmable rule. On the first failure it stops issuing elements and reports a shortened vector length. The result is deterministic: the length shrinks only because of a failed test. It can drop to zero, and it can optionally keep the element that failed.

A run begins with a one-cycle `start` that captures the length, the predicate mask and the test configuration. Elements whose predicate bit is clear are stepped over, one per cycle, without a request. Each active element raises `elem_req` with its index and waits for `res_valid`. A one-cycle `done` pulse carries the final length in `newvl`, and the controller is idle again in the next cycle.

Top module: `ffirst_loop_ctrl`

## Requirements
- R1: Elements are visited in ascending order from index 0. `elem_req` is high only for a predicate-enabled element below the captured length, and `elem_idx` holds that element's index.
- R2: With `rec_en`=1, the tested bit is `res_cr[cr_sel]`, using the bit encoding 0=lt, 1=gt, 2=eq, 3=ov. The element fails when that bit equals `inv`.
- R3: With `rec_en`=0 and `cmp_mode`=1, only `res_cr[2]` (eq) is tested and `cr_sel` is ignored. The element fails when eq equals `inv`.
- R4: A failing element is not committed unless the inclusive option is in effect. After a failure, no higher element is requested and the run ends in the same cycle.
- R5: The final length is the failing index when `incl` is clear, or that index plus one when `incl` is set. `incl` has an effect only when `rec_en`=0.
- R6: A failure at element 0 gives `newvl`=0. A start with `vl_in`=0 gives `done` with `newvl`=0 one cycle later, with no request.
- R7: If no element fails, `newvl` equals the captured length. With `rec_en`=0 and `cmp_mode`=0, no condition test is made. A `vl_in` above MAXVL is captured as MAXVL.
- R8: A raised `res_fpexc` makes that element fail. `exc_flag` pulses together with `done` only when the inclusive option is in effect.
- R9: Masked elements are never requested, tested or committed, and cannot cause a failure. A masked final element still ends the run with the full length.
- R10: `done`, `commit` and `exc_flag` are single-cycle registered pulses. `start` during a run and `res_valid` without a request are ignored. After reset, every output strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; ignored while one is in progress |
| vl_in | input | LEN_W | Requested vector length |
| pred_mask | input | MAXVL | Per-element enable mask |
| rec_en | input | 1 | Condition recording mode: test the bit chosen by cr_sel |
| cmp_mode | input | 1 | Compare-like mode: test the eq bit |
| inv | input | 1 | Value of the tested bit that counts as failure |
| cr_sel | input | 2 | Bit select: 0=lt, 1=gt, 2=eq, 3=ov |
| incl | input | 1 | Keep the failing element in the length (rec_en=0 only) |
| res_valid | input | 1 | Result for the requested element is present |
| res_cr | input | 4 | Condition field of the result |
| res_fpexc | input | 1 | Floating-point exception raised by the element |
| elem_req | output | 1 | Requesting the element at elem_idx |
| elem_idx | output | IDX_W | Current element index |
| commit | output | 1 | Previous element's result is kept |
| commit_idx | output | IDX_W | Index of the committed element |
| done | output | 1 | Run finished, newvl valid |
| newvl | output | LEN_W | Resulting vector length |
| exc_flag | output | 1 | Exception of an included failing element is signalled |

## Verification
The hardest situations to reach are those where the controller must not react. These are a stray `start` arriving mid-run, `res_valid` held high while a masked element is being stepped over, and a masked element whose condition field would fail the test. The bench keeps `res_valid` asserted on a stall pattern that does not follow `elem_req`. It supplies failing condition values at masked indices, and in one long run it pulses `start` again with a different length. A cycle model of the requirements checks every output on every clock, so a wrongly accepted event shows up in the cycle where it occurs.

// File: rtl/ffl_pkg.sv
package ffl_pkg;

  typedef struct packed {
    logic       rec_en;
    logic       cmp_mode;
    logic       inv;
    logic [1:0] sel;
    logic       incl;
  } ffl_cfg_t;

  localparam int CR_LT = 0;
  localparam int CR_GT = 1;
  localparam int CR_EQ = 2;
  localparam int CR_OV = 3;

endpackage

// File: rtl/ffl_cond_eval.sv
module ffl_cond_eval
  import ffl_pkg::*;
(
  input  ffl_cfg_t   cfg,
  input  logic [3:0] cr,
  input  logic       fpexc,
  output logic       fail,
  output logic       incl_eff
);

  logic test_on;
  logic tested;

  always_comb begin
    test_on  = cfg.rec_en | cfg.cmp_mode;
    tested   = cfg.rec_en ? cr[cfg.sel] : cr[CR_EQ];
    fail     = (test_on && (tested == cfg.inv)) || fpexc;
    incl_eff = cfg.incl & ~cfg.rec_en;
  end

endmodule

// File: rtl/ffl_elem_seq.sv
module ffl_elem_seq
  import ffl_pkg::*;
#(
  parameter int MAXVL = 64,
  localparam int IDX_W = (MAXVL > 1) ? $clog2(MAXVL) : 1,
  localparam int LEN_W = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] vl_in,
  input  logic [MAXVL-1:0] pred_in,
  input  ffl_cfg_t         cfg_in,
  input  logic             res_valid,
  input  logic             fail,
  input  logic             incl_eff,
  input  logic             fpexc,
  output ffl_cfg_t         cfg_q,
  output logic             elem_req,
  output logic [IDX_W-1:0] elem_idx,
  output logic             commit,
  output logic [IDX_W-1:0] commit_idx,
  output logic             done,
  output logic [LEN_W-1:0] newvl,
  output logic             exc
);

  localparam logic [LEN_W-1:0] MAXVL_L = LEN_W'(MAXVL);

  logic             busy;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] vl_q;
  logic [MAXVL-1:0] pred_q;
  logic [LEN_W-1:0] vl_clamp;
  logic             active;
  logic             last;

  assign vl_clamp = (vl_in > MAXVL_L) ? MAXVL_L : vl_in;
  assign active   = pred_q[idx];
  assign last     = (LEN_W'(idx) + LEN_W'(1)) == vl_q;
  assign elem_req = busy & active;
  assign elem_idx = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      idx        <= '0;
      vl_q       <= '0;
      pred_q     <= '0;
      cfg_q      <= '0;
      commit     <= 1'b0;
      commit_idx <= '0;
      done       <= 1'b0;
      newvl      <= '0;
      exc        <= 1'b0;
    end else begin
      commit <= 1'b0;
      done   <= 1'b0;
      exc    <= 1'b0;
      if (!busy) begin
        if (start) begin
          idx    <= '0;
          vl_q   <= vl_clamp;
          pred_q <= pred_in;
          cfg_q  <= cfg_in;
          if (vl_clamp == '0) begin
            done  <= 1'b1;
            newvl <= '0;
          end else begin
            busy <= 1'b1;
          end
        end
      end else if (!active) begin
        if (last) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          newvl <= vl_q;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (res_valid) begin
        commit     <= ~fail | incl_eff;
        commit_idx <= idx;
        exc        <= fpexc & incl_eff;
        if (fail) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          newvl <= LEN_W'(idx) + LEN_W'(incl_eff);
        end else if (last) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          newvl <= vl_q;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R1: a requested index always lies inside the captured length
  a_r1_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (LEN_W'(idx) < vl_q));

  // R10: once done is reported nothing is requested
  a_r10_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !elem_req);

  // R5: the reported length never exceeds the captured one
  a_r5_newvl_bound: assert property (@(posedge clk) disable iff (rst)
    done |-> (newvl <= vl_q));

  // R8: the exception flag only accompanies an included, final element
  a_r8_exc_with_done: assert property (@(posedge clk) disable iff (rst)
    exc |-> (done && commit));

  // R4: a commit follows an accepted request
  a_r4_commit_from_req: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(elem_req && res_valid));

  // R9: committed elements are always predicate-enabled
  a_r9_masked_no_commit: assert property (@(posedge clk) disable iff (rst)
    commit |-> pred_q[commit_idx]);

endmodule

// File: rtl/ffirst_loop_ctrl.sv
module ffirst_loop_ctrl
  import ffl_pkg::*;
#(
  parameter int MAXVL = 64,
  localparam int IDX_W = (MAXVL > 1) ? $clog2(MAXVL) : 1,
  localparam int LEN_W = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] vl_in,
  input  logic [MAXVL-1:0] pred_mask,
  input  logic             rec_en,
  input  logic             cmp_mode,
  input  logic             inv,
  input  logic [1:0]       cr_sel,
  input  logic             incl,
  input  logic             res_valid,
  input  logic [3:0]       res_cr,
  input  logic             res_fpexc,
  output logic             elem_req,
  output logic [IDX_W-1:0] elem_idx,
  output logic             commit,
  output logic [IDX_W-1:0] commit_idx,
  output logic             done,
  output logic [LEN_W-1:0] newvl,
  output logic             exc_flag
);

  ffl_cfg_t cfg_in;
  ffl_cfg_t cfg_q;
  logic     fail;
  logic     incl_eff;

  assign cfg_in = '{rec_en: rec_en, cmp_mode: cmp_mode, inv: inv,
                    sel: cr_sel, incl: incl};

  ffl_cond_eval u_eval (
    .cfg      (cfg_q),
    .cr       (res_cr),
    .fpexc    (res_fpexc),
    .fail     (fail),
    .incl_eff (incl_eff)
  );

  ffl_elem_seq #(.MAXVL(MAXVL)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .vl_in      (vl_in),
    .pred_in    (pred_mask),
    .cfg_in     (cfg_in),
    .res_valid  (res_valid),
    .fail       (fail),
    .incl_eff   (incl_eff),
    .fpexc      (res_fpexc),
    .cfg_q      (cfg_q),
    .elem_req   (elem_req),
    .elem_idx   (elem_idx),
    .commit     (commit),
    .commit_idx (commit_idx),
    .done       (done),
    .newvl      (newvl),
    .exc        (exc_flag)
  );

endmodule

// File: tb/sim_ffirst_loop_ctrl.sv
module sim_ffirst_loop_ctrl;

  localparam int MAXVL      = 16;
  localparam int IDX_W      = 4;
  localparam int LEN_W      = 5;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [LEN_W-1:0] vl_in = '0;
  logic [MAXVL-1:0] pred_mask = '0;
  logic             rec_en = 1'b0, cmp_mode = 1'b0, inv = 1'b0, incl = 1'b0;
  logic [1:0]       cr_sel = 2'd0;
  logic             res_valid = 1'b0;
  logic [3:0]       res_cr = 4'd0;
  logic             res_fpexc = 1'b0;
  logic             elem_req, commit, done, exc_flag;
  logic [IDX_W-1:0] elem_idx, commit_idx;
  logic [LEN_W-1:0] newvl;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [3:0] cr_a [MAXVL];
  logic       fp_a [MAXVL];

  always #(CLK_PERIOD/2) clk = ~clk;

  ffirst_loop_ctrl #(.MAXVL(MAXVL)) u0 (
    .clk(clk), .rst(rst), .start(start), .vl_in(vl_in), .pred_mask(pred_mask),
    .rec_en(rec_en), .cmp_mode(cmp_mode), .inv(inv), .cr_sel(cr_sel), .incl(incl),
    .res_valid(res_valid), .res_cr(res_cr), .res_fpexc(res_fpexc),
    .elem_req(elem_req), .elem_idx(elem_idx), .commit(commit),
    .commit_idx(commit_idx), .done(done), .newvl(newvl), .exc_flag(exc_flag)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Behavioural reference model, updated on each rising edge
  int       m_busy = 0, m_idx = 0, m_vl = 0;
  logic [MAXVL-1:0] m_pred = '0;
  int       m_rec = 0, m_cmp = 0, m_inv = 0, m_sel = 0, m_incl = 0;
  int       e_commit = 0, e_cidx = 0, e_done = 0, e_newvl = 0, e_exc = 0;

  always @(posedge clk) begin
    int t, f, ie, lastv;
    cycles++;
    e_commit = 0; e_done = 0; e_exc = 0;
    if (rst) begin
      m_busy = 0; m_idx = 0; e_newvl = 0; e_cidx = 0;
    end else if (m_busy == 0) begin
      if (start) begin
        m_vl = (int'(vl_in) > MAXVL) ? MAXVL : int'(vl_in);
        m_pred = pred_mask; m_idx = 0;
        m_rec = rec_en; m_cmp = cmp_mode; m_inv = inv; m_sel = cr_sel; m_incl = incl;
        if (m_vl == 0) begin e_done = 1; e_newvl = 0; end
        else m_busy = 1;
      end
    end else begin
      lastv = (m_idx == m_vl - 1);
      if (!m_pred[m_idx]) begin
        if (lastv) begin m_busy = 0; e_done = 1; e_newvl = m_vl; end
        else m_idx++;
      end else if (res_valid) begin
        if (m_rec != 0) t = res_cr[m_sel];
        else t = res_cr[2];
        f  = (((m_rec != 0) || (m_cmp != 0)) && (t == m_inv)) || res_fpexc;
        ie = (m_incl != 0) && (m_rec == 0);
        e_commit = (!f || ie) ? 1 : 0;
        e_cidx = m_idx;
        e_exc = (res_fpexc && ie) ? 1 : 0;
        if (f) begin m_busy = 0; e_done = 1; e_newvl = m_idx + ie; end
        else if (lastv) begin m_busy = 0; e_done = 1; e_newvl = m_vl; end
        else m_idx++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R1", "elem_req", elem_req, (m_busy != 0 && m_pred[m_idx]) ? 1 : 0);
      if (m_busy != 0 && m_pred[m_idx]) chk("R1", "elem_idx", elem_idx, m_idx);
      chk("R4", "commit", commit, e_commit);
      if (e_commit != 0) chk("R4", "commit_idx", commit_idx, e_cidx);
      chk("R10", "done", done, e_done);
      if (e_done != 0) chk("R5", "newvl", newvl, e_newvl);
      chk("R8", "exc_flag", exc_flag, e_exc);
    end
    if (cycles > 150000) begin
      chk("R10", "watchdog", 1, 0);
      finish_up();
    end
  end

  task automatic fill(input logic [3:0] cr);
    for (int i = 0; i < MAXVL; i++) begin cr_a[i] = cr; fp_a[i] = 1'b0; end
  endtask

  task automatic run(input string tag, input int vl, input logic [MAXVL-1:0] pm,
                     input logic r, input logic c, input logic iv, input logic [1:0] s,
                     input logic ic, input bit ghost, input int exp_vl, input int exp_exc);
    int got_vl = -1, got_exc = 0, ncommit = 0, exp_commit = 0;
    @(posedge clk); #1;
    vl_in = LEN_W'(vl); pred_mask = pm; rec_en = r; cmp_mode = c; inv = iv;
    cr_sel = s; incl = ic; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (done) begin got_vl = newvl; got_exc = exc_flag; break; end
      res_valid = (k % 3) != 2;
      res_cr    = cr_a[elem_idx];
      res_fpexc = fp_a[elem_idx];
      start     = ghost && (k == 4);
      if (ghost && k == 4) vl_in = 5'd3;
      @(posedge clk); #1;
      start = 1'b0;
      if (commit) ncommit++;
    end
    res_valid = 1'b0; res_fpexc = 1'b0;
    chk(tag, "final length", got_vl, exp_vl);
    chk(tag, "exception at end", got_exc, exp_exc);
    for (int i = 0; i < exp_vl; i++) if (pm[i]) exp_commit++;
    chk("R4", "commit count", ncommit, exp_commit);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "reset done", done, 0);
    chk("R10", "reset commit", commit, 0);
    chk("R10", "reset elem_req", elem_req, 0);
    rst = 1'b0;

    // R2: eq tested, inv=0 -> fails where eq clear
    fill(4'b0100); cr_a[5] = 4'b0000;
    run("R2", 12, '1, 1, 0, 0, 2'd2, 0, 0, 5, 0);
    // R5: lt tested, inv=1, incl ignored under rec_en
    fill(4'b0100); cr_a[3] = 4'b0001;
    run("R5", 10, '1, 1, 0, 1, 2'd0, 1, 0, 3, 0);
    // R3: compare mode, sel ignored, inclusive keeps element 6
    fill(4'b0001); cr_a[6] = 4'b0100;
    run("R3", 14, '1, 0, 1, 1, 2'd0, 1, 0, 7, 0);
    // R6: element 0 fails
    fill(4'b0100); cr_a[0] = 4'b0000;
    run("R6", 8, '1, 1, 0, 0, 2'd2, 0, 0, 0, 0);
    // R6: zero length request
    run("R6", 0, '1, 1, 0, 0, 2'd2, 0, 0, 0, 0);
    // R7: no test mode, stray start mid-run ignored (R10)
    fill(4'b0000);
    run("R7", 9, '1, 0, 0, 0, 2'd2, 0, 1, 9, 0);
    // R8: exception, exclusive then inclusive
    fill(4'b0100); fp_a[4] = 1'b1;
    run("R8", 11, '1, 0, 1, 0, 2'd2, 0, 0, 4, 0);
    run("R8", 11, '1, 0, 1, 0, 2'd2, 1, 0, 5, 1);
    // R9: masked failing element skipped
    fill(4'b0100); cr_a[2] = 4'b0000; cr_a[6] = 4'b0000;
    run("R9", 12, 16'hFFFB, 1, 0, 0, 2'd2, 0, 0, 6, 0);
    // R9: masked final element
    fill(4'b0100); cr_a[4] = 4'b0000;
    run("R9", 5, 16'h000F, 1, 0, 0, 2'd2, 0, 0, 5, 0);
    // R7: length clamp
    fill(4'b0000);
    run("R7", 20, '1, 0, 0, 0, 2'd0, 0, 0, 16, 0);
    // R2: overflow bit tested with inv=1
    fill(4'b0100); cr_a[10] = 4'b1100;
    run("R2", 16, 16'h7FFF, 1, 0, 1, 2'd3, 0, 0, 10, 0);

    repeat (3) @(posedge clk);
    finish_up();
  end

endmodule